// File: doc/BRIEF.md
# Real-mode interrupt entry sequencer

This block takes a pending interrupt into service at an instruction boundary. A raise request stores an 8-bit vector number and marks the interrupt as pending. When the execution core reaches a boundary, it asks the block whether the next opcode fetch may go ahead. If a pending interrupt can be taken, the block denies the fetch and runs a fixed sequence instead:

1. It stacks the flags word, the code segment and the instruction pointer on a 16-bit stack.
2. It clears the interrupt-enable and trap bits in the live flags.
3. It reads the new code segment and instruction pointer from the vector table at the bottom of memory.
4. It writes the new values into the register file through side ports.

All memory traffic uses one word-wide request channel with valid/ready flow control. The master raises `mem_valid_o` and holds the address, the direction and the write data steady until the memory accepts them by asserting `mem_ready_i` at a clock edge. The memory may hold `mem_ready_i` low for any number of cycles. For a read, `mem_rdata_i` is sampled in the cycle of the handshake. The control pins (raise, boundary, halt, fetch grant, done) are plain single-cycle signals. A halt request is remembered until reset and blocks all further fetching and servicing.

Top module: `rm_irq_entry`

## Requirements
- R1: A one-cycle `raise_i` stores `raise_vec_i` and sets `pending_o` from the next cycle on. A later raise replaces the stored vector.
- R2: No memory request is made and `busy_o` stays low unless `boundary_i` is seen while idle with an interrupt that can be taken. `fetch_ok_o` is never high while `busy_o` is high.
- R3: The three stack writes go in the order flags, code segment, instruction pointer. Before each write the stack offset is lowered by 2, and each word goes to SS:offset. `sp_o` is written with each new offset, so the final offset is the starting one minus 6, modulo 2^16.
- R4: The stacked flags word carries the old values of bit 9 (interrupt enable) and bit 8 (trap). During the first stack write, `flags_o` is written with both of these bits cleared and all other bits kept.
- R5: After the pushes, the block reads the new code segment from physical address vector*4+2 and then the new instruction pointer from vector*4. It writes them through `cs_o` and `ip_o`.
- R6: Every stack address is (segment*16 + offset) truncated to 20 bits, so addresses near the top of memory wrap to low memory.
- R7: For a vector other than 0 and 2 with flags bit 9 clear, a boundary grants the fetch (`fetch_ok_o` high) and the interrupt stays pending. Once bit 9 is set, the next boundary takes it.
- R8: Vectors 0 and 2 are taken at a boundary even when flags bit 9 is clear.
- R9: After `halt_i`, `halted_o` stays high until reset. Boundaries then neither grant a fetch nor start service, even for vectors 0 and 2.
- R10: `done_o` is high for exactly one cycle, in the same cycle as the `cs_we_o` and `ip_we_o` strobes. `pending_o` then clears unless a raise arrived during the service, in which case it stays set.
- R11: While `mem_valid_o` is high and `mem_ready_i` is low, address, direction and write data hold steady. A write word places bits 7:0 at the addressed byte and bits 15:8 at the next byte.
- R12: A boundary while idle with nothing pending asserts `fetch_ok_o` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 1 | Raise an interrupt (one-cycle pulse) |
| raise_vec_i | input | 8 | Vector number stored with the raise |
| boundary_i | input | 1 | Core is at an instruction boundary, before the opcode fetch |
| halt_i | input | 1 | Halt request |
| fetch_ok_o | output | 1 | Opcode fetch may proceed (same cycle as boundary) |
| pending_o | output | 1 | An interrupt is waiting |
| busy_o | output | 1 | Entry sequence in progress |
| halted_o | output | 1 | Halt has been seen |
| done_o | output | 1 | New CS:IP is being written (one cycle) |
| flags_i | input | 16 | Current flags |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| sp_i | input | 16 | Current stack offset |
| ss_i | input | 16 | Current stack segment |
| flags_we_o | output | 1 | Flags write strobe |
| flags_o | output | 16 | Flags write value |
| cs_we_o | output | 1 | Code segment write strobe |
| cs_o | output | 16 | New code segment |
| ip_we_o | output | 1 | Instruction pointer write strobe |
| ip_o | output | 16 | New instruction pointer |
| sp_we_o | output | 1 | Stack offset write strobe |
| sp_o | output | 16 | New stack offset |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 20 | Physical word address |
| mem_wdata_o | output | 16 | Write word |
| mem_rdata_i | input | 16 | Read word, sampled at the handshake |

## Verification
The assertions take `raise_i`, `boundary_i` and `halt_i` to be single-cycle pulses. They also assume the register-file inputs are stable while `busy_o` is high, and that the memory may stall but never answers without a valid request. The stimulus drives every control pulse for exactly one cycle, on the falling edge. It changes the register values only between services. The memory model asserts ready in two of every three cycles, so the hold-while-stalled rule is exercised during every sequence.

// File: rtl/rm_irq_pkg.sv
package rm_irq_pkg;
  localparam int IEN_BIT = 9;
  localparam int TRAP_BIT = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_READ_CS,
    ST_READ_IP,
    ST_LOAD
  } seq_state_t;
endpackage

// File: rtl/rm_irq_pending.sv
module rm_irq_pending #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raise_i,
  input  logic [VW-1:0] vec_i,
  input  logic          start_i,
  input  logic          busy_i,
  input  logic          load_i,
  output logic          pend_o,
  output logic [VW-1:0] vec_o
);
  logic rearm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o  <= 1'b0;
      vec_o   <= '0;
      rearm_q <= 1'b0;
    end else begin
      if (raise_i) vec_o <= vec_i;
      if (load_i) begin
        pend_o  <= rearm_q | raise_i;
        rearm_q <= 1'b0;
      end else begin
        if (raise_i) pend_o <= 1'b1;
        if (raise_i && (busy_i || start_i)) rearm_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rm_irq_addr.sv
module rm_irq_addr #(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input  logic [DW-1:0] seg_i,
  input  logic [DW-1:0] off_i,
  output logic [AW-1:0] phys_o
);
  localparam int SW = (DW + 4 > AW) ? DW + 5 : AW + 1;
  logic [SW-1:0] sum;

  always_comb begin
    sum    = (SW'(seg_i) << 4) + SW'(off_i);
    phys_o = sum[AW-1:0];
  end
endmodule

// File: rtl/rm_irq_seq.sv
module rm_irq_seq
  import rm_irq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [VW-1:0] vec_i,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] ss_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [DW-1:0] push_seg_o,
  output logic [DW-1:0] push_off_o,
  output logic          busy_o,
  output logic          load_o,
  output logic          flags_we_o,
  output logic [DW-1:0] flags_o,
  output logic          cs_we_o,
  output logic [DW-1:0] cs_o,
  output logic          ip_we_o,
  output logic [DW-1:0] ip_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << IEN_BIT) | (DW'(1) << TRAP_BIT));

  seq_state_t    st_q;
  logic [DW-1:0] fl_q, cs_q, ip_q, sp_q, ss_q, ncs_q, nip_q;
  logic [VW-1:0] vec_q;
  logic          is_push, is_read, hs;
  logic [DW-1:0] sp_dec;

  always_comb begin
    is_push = (st_q == ST_PUSH_FL) || (st_q == ST_PUSH_CS) || (st_q == ST_PUSH_IP);
    is_read = (st_q == ST_READ_CS) || (st_q == ST_READ_IP);
    hs      = (is_push || is_read) && mem_ready_i;
    sp_dec  = sp_q - DW'(2);
    push_seg_o = ss_q;
    push_off_o = sp_dec;
    mem_valid_o = is_push || is_read;
    mem_we_o    = is_push;
    if (is_push)                mem_addr_o = push_addr_i;
    else if (st_q == ST_READ_CS) mem_addr_o = AW'({vec_q, 2'b10});
    else                        mem_addr_o = AW'({vec_q, 2'b00});
    case (st_q)
      ST_PUSH_FL: mem_wdata_o = fl_q;
      ST_PUSH_CS: mem_wdata_o = cs_q;
      ST_PUSH_IP: mem_wdata_o = ip_q;
      default:    mem_wdata_o = '0;
    endcase
    sp_we_o    = is_push && mem_ready_i;
    sp_o       = sp_dec;
    flags_we_o = (st_q == ST_PUSH_FL) && mem_ready_i;
    flags_o    = fl_q & CLR_MASK;
    load_o     = (st_q == ST_LOAD);
    cs_we_o    = load_o;
    ip_we_o    = load_o;
    cs_o       = ncs_q;
    ip_o       = nip_q;
    busy_o     = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      fl_q  <= '0; cs_q <= '0; ip_q <= '0; sp_q <= '0; ss_q <= '0;
      ncs_q <= '0; nip_q <= '0; vec_q <= '0;
    end else begin
      if (is_push && hs) sp_q <= sp_dec;
      case (st_q)
        ST_IDLE: if (start_i) begin
          fl_q <= flags_i; cs_q <= cs_i; ip_q <= ip_i;
          sp_q <= sp_i; ss_q <= ss_i; vec_q <= vec_i;
          st_q <= ST_PUSH_FL;
        end
        ST_PUSH_FL: if (hs) st_q <= ST_PUSH_CS;
        ST_PUSH_CS: if (hs) st_q <= ST_PUSH_IP;
        ST_PUSH_IP: if (hs) st_q <= ST_READ_CS;
        ST_READ_CS: if (hs) begin
          ncs_q <= mem_rdata_i;
          st_q  <= ST_READ_IP;
        end
        ST_READ_IP: if (hs) begin
          nip_q <= mem_rdata_i;
          st_q  <= ST_LOAD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rm_irq_entry.sv
module rm_irq_entry
  import rm_irq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raise_i,
  input  logic [VW-1:0] raise_vec_i,
  input  logic          boundary_i,
  input  logic          halt_i,
  output logic          fetch_ok_o,
  output logic          pending_o,
  output logic          busy_o,
  output logic          halted_o,
  output logic          done_o,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] ss_i,
  output logic          flags_we_o,
  output logic [DW-1:0] flags_o,
  output logic          cs_we_o,
  output logic [DW-1:0] cs_o,
  output logic          ip_we_o,
  output logic [DW-1:0] ip_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          halt_q, stop, gate_open, start, load;
  logic [VW-1:0] pend_vec;
  logic [DW-1:0] push_seg, push_off;
  logic [AW-1:0] push_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= 1'b0;
    else if (halt_i) halt_q <= 1'b1;
  end

  always_comb begin
    stop       = halt_q || halt_i;
    gate_open  = (pend_vec == VW'(0)) || (pend_vec == VW'(2)) || flags_i[IEN_BIT];
    start      = boundary_i && !busy_o && !stop && pending_o && gate_open;
    fetch_ok_o = boundary_i && !busy_o && !stop && !start;
    halted_o   = halt_q;
    done_o     = load;
  end

  rm_irq_pending #(.VW(VW)) pend_i (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .vec_i(raise_vec_i),
    .start_i(start), .busy_i(busy_o), .load_i(load),
    .pend_o(pending_o), .vec_o(pend_vec)
  );

  rm_irq_addr #(.DW(DW), .AW(AW)) addr_i (
    .seg_i(push_seg), .off_i(push_off), .phys_o(push_addr)
  );

  rm_irq_seq #(.DW(DW), .AW(AW), .VW(VW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vec_i(pend_vec),
    .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .sp_i(sp_i), .ss_i(ss_i),
    .push_addr_i(push_addr), .push_seg_o(push_seg), .push_off_o(push_off),
    .busy_o(busy_o), .load_o(load),
    .flags_we_o(flags_we_o), .flags_o(flags_o),
    .cs_we_o(cs_we_o), .cs_o(cs_o), .ip_we_o(ip_we_o), .ip_o(ip_o),
    .sp_we_o(sp_we_o), .sp_o(sp_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );
endmodule

// File: rtl/rm_irq_entry_chk.sv
module rm_irq_entry_chk #(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          done_o,
  input logic          fetch_ok_o,
  input logic          halted_o,
  input logic          busy_o,
  input logic          flags_we_o
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
    $stable(mem_we_o) && $stable(mem_wdata_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);

  // R9
  halt_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !fetch_ok_o);

  // R2
  fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ok_o |-> !busy_o);

  // R3
  flags_then_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we_o |=> mem_valid_o && mem_we_o);
endmodule

bind rm_irq_entry rm_irq_entry_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .done_o(done_o), .fetch_ok_o(fetch_ok_o), .halted_o(halted_o),
  .busy_o(busy_o), .flags_we_o(flags_we_o)
);

// File: tb/rm_irq_entry_tb.sv
module rm_irq_entry_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        raise_i = 0, boundary_i = 0, halt_i = 0, mem_ready = 0;
  logic [7:0]  raise_vec = 0;
  logic        fetch_ok, pending, busy, halted, done;
  logic [15:0] rf_flags = 0, rf_cs = 0, rf_ip = 0, rf_sp = 0, rf_ss = 0;
  logic        flags_we, cs_we, ip_we, sp_we, mem_valid, mem_we;
  logic [15:0] flags_w, cs_w, ip_w, sp_w, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [36:0] exp_q[$];
  int rcnt = 0;

  function automatic logic [15:0] rd_of(input logic [19:0] a);
    return a[15:0] ^ 16'hC35A ^ {12'h0, a[19:16]};
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({s, 4'h0} + {4'h0, o});
  endfunction

  assign mem_rdata = mem_valid ? rd_of(mem_addr) : 16'h0;

  rm_irq_entry dut_i (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .raise_vec_i(raise_vec),
    .boundary_i(boundary_i), .halt_i(halt_i), .fetch_ok_o(fetch_ok),
    .pending_o(pending), .busy_o(busy), .halted_o(halted), .done_o(done),
    .flags_i(rf_flags), .cs_i(rf_cs), .ip_i(rf_ip), .sp_i(rf_sp), .ss_i(rf_ss),
    .flags_we_o(flags_we), .flags_o(flags_w), .cs_we_o(cs_we), .cs_o(cs_w),
    .ip_we_o(ip_we), .ip_o(ip_w), .sp_we_o(sp_we), .sp_o(sp_w),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // register-file model
  always @(posedge clk) begin
    if (flags_we) rf_flags <= flags_w;
    if (cs_we)    rf_cs    <= cs_w;
    if (ip_we)    rf_ip    <= ip_w;
    if (sp_we)    rf_sp    <= sp_w;
  end

  // memory back-pressure: ready two cycles out of three
  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    #2 mem_ready <= (rcnt % 3) != 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: compares each accepted memory request against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected memory request", {11'h0, mem_we, mem_addr}, 0);
      end else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        chk(mem_we == e[36] && mem_addr == e[35:16], "R3/R5/R6 request address",
            {11'h0, mem_we, mem_addr}, {11'h0, e[36:16]});
        if (e[36]) chk(mem_wdata == e[15:0], "R3/R4 stacked word", mem_wdata, e[15:0]);
      end
    end
  end

  task automatic set_regs(input logic [15:0] f, c, i, s, ss);
    @(negedge clk);
    rf_flags = f; rf_cs = c; rf_ip = i; rf_sp = s; rf_ss = ss;
  endtask

  task automatic raise(input logic [7:0] v);
    @(negedge clk);
    raise_i = 1; raise_vec = v;
    @(negedge clk);
    raise_i = 0;
    chk(pending == 1'b1, "R1 pending after raise", pending, 1);
  endtask

  // boundary that must grant the fetch and leave the interrupt waiting
  task automatic boundary_notake(input string req, input bit exp_pend);
    @(negedge clk);
    boundary_i = 1;
    #1 chk(fetch_ok == 1'b1, req, fetch_ok, 1);
    @(negedge clk);
    boundary_i = 0;
    chk(busy == 0 && mem_valid == 0 && pending == exp_pend, req,
        {busy, mem_valid, pending}, {2'b00, exp_pend});
  endtask

  // boundary that must start service of vector v
  task automatic boundary_take(input logic [7:0] v, input bit reraise, input string req);
    logic [15:0] f0, c0, i0, s0, ss0;
    int w;
    f0 = rf_flags; c0 = rf_cs; i0 = rf_ip; s0 = rf_sp; ss0 = rf_ss;
    exp_q.push_back({1'b1, phys(ss0, s0 - 16'd2), f0});
    exp_q.push_back({1'b1, phys(ss0, s0 - 16'd4), c0});
    exp_q.push_back({1'b1, phys(ss0, s0 - 16'd6), i0});
    exp_q.push_back({1'b0, 10'h0, v, 2'b10, 16'h0});
    exp_q.push_back({1'b0, 10'h0, v, 2'b00, 16'h0});
    @(negedge clk);
    boundary_i = 1;
    #1 chk(fetch_ok == 1'b0, req, fetch_ok, 0);
    @(negedge clk);
    boundary_i = 0;
    if (reraise) begin
      raise_i = 1; raise_vec = 8'h77;
      @(negedge clk);
      raise_i = 0;
    end
    w = 0;
    while (!done && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, "R10 done reached", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    chk(exp_q.size() == 0, "R3 all requests seen", exp_q.size(), 0);
    chk(rf_cs == rd_of({10'h0, v, 2'b10}), "R5 new CS", rf_cs, rd_of({10'h0, v, 2'b10}));
    chk(rf_ip == rd_of({10'h0, v, 2'b00}), "R5 new IP", rf_ip, rd_of({10'h0, v, 2'b00}));
    chk(rf_sp == s0 - 16'd6, "R3 final SP", rf_sp, s0 - 16'd6);
    chk(rf_flags == (f0 & 16'hFCFF), "R4 flags cleared", rf_flags, f0 & 16'hFCFF);
    chk(pending == reraise, "R10 pending after done", pending, reraise);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_valid == 0 && pending == 0 && halted == 0,
        "reset state", {busy, done, mem_valid, pending, halted}, 0);

    // R12 nothing pending
    boundary_notake("R12 fetch granted when idle", 1'b0);

    // R1/R2 raise alone does nothing without a boundary
    set_regs(16'h0202, 16'h1234, 16'h0100, 16'h2000, 16'h3000);
    raise(8'h21);
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_valid == 0, "R2 no activity without boundary", {busy, mem_valid}, 0);
    boundary_take(8'h21, 1'b0, "R7 taken with IF set");

    // R4 trap and enable both set
    set_regs(16'h0347, 16'hABCD, 16'h5555, 16'h0100, 16'h0040);
    raise(8'h08);
    boundary_take(8'h08, 1'b0, "R4 service with trap set");

    // R7 gate closed, then opened
    set_regs(16'h0046, 16'h1111, 16'h2222, 16'h0800, 16'h0000);
    raise(8'h10);
    boundary_notake("R7 gated by clear IF", 1'b1);
    set_regs(16'h0246, 16'h1111, 16'h2222, 16'h0800, 16'h0000);
    boundary_take(8'h10, 1'b0, "R7 taken after IF set");

    // R8 vectors 0 and 2 bypass the gate, vector 1 does not
    set_regs(16'h0000, 16'h0F00, 16'h0010, 16'h0400, 16'h0100);
    raise(8'h00);
    boundary_take(8'h00, 1'b0, "R8 vector 0 bypass");
    raise(8'h02);
    boundary_take(8'h02, 1'b0, "R8 vector 2 bypass");
    raise(8'h01);
    boundary_notake("R8 vector 1 gated", 1'b1);

    // R6 wrap at the top of memory (vector 1 still pending, now enabled)
    set_regs(16'h0200, 16'h4321, 16'h8765, 16'h0004, 16'hFFFF);
    raise(8'h40);
    boundary_take(8'h40, 1'b0, "R6 wrap service");

    // R10 raise during service stays pending
    set_regs(16'h0200, 16'h0001, 16'h0002, 16'h1000, 16'h2000);
    raise(8'hFF);
    boundary_take(8'hFF, 1'b1, "R10 re-raise service");
    set_regs(16'h0200, 16'h0003, 16'h0004, 16'h1000, 16'h2000);
    boundary_take(8'h77, 1'b0, "R10 queued vector serviced");

    // R9 halt blocks everything
    @(negedge clk);
    halt_i = 1;
    @(negedge clk);
    halt_i = 0;
    raise(8'h00);
    @(negedge clk);
    boundary_i = 1;
    #1 chk(fetch_ok == 1'b0, "R9 no fetch when halted", fetch_ok, 0);
    @(negedge clk);
    boundary_i = 0;
    chk(busy == 0 && halted == 1 && pending == 1, "R9 no service when halted",
        {busy, halted, pending}, 3'b011);
    repeat (3) @(negedge clk);
    chk(mem_valid == 0 && halted == 1, "R9 halt sticky", {mem_valid, halted}, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule